// File: doc/BRIEF.md
# Configurable External Interrupt Trigger Detector

This block conditions six interrupt request lines before they reach an interrupt controller. Four of the lines come from external pins and two come from on-chip programmable logic. Each line is first brought into the clock domain by a two-flop synchroniser. A per-line detector then evaluates a programmable trigger condition: high level, low level, rising edge or falling edge.

Level-mode lines present the synchronised input directly. Edge-mode lines capture each event in a sticky latch. The latch holds until software writes a one to that line's bit in the clear register. An enable mask qualifies every line before it leaves on the pending vector. Priority arbitration and vector generation are done downstream.

Software reaches three registers through a simple word-addressed write port with a combinational read path. Address 0 holds the trigger modes. Address 1 holds the enable mask. Address 2 is the write-one-to-clear register for edge latches. Line index 0 is logic-array line 0, indices 1 to 4 are external pins 0 to 3, and index 5 is logic-array line 1.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset, pending_o is 0 and the mode and enable registers read 0.
- R2: The mode register at address 0 holds line k's 2-bit field at bits [2k+1:2k]. The encoding is 00 high level, 01 low level, 10 rising edge and 11 falling edge. Read bits above bit 11 are 0.
- R3: The enable register at address 1 masks the lines: pending_o[k] is 0 whenever enable bit k is 0. An edge latch survives being masked and reappears when the line is re-enabled.
- R4: In high-level mode, pending_o[k] equals the input as sampled two clock edges earlier, gated by enable.
- R5: In low-level mode, pending_o[k] equals the inverse of the input as sampled two clock edges earlier, gated by enable.
- R6: In rising-edge mode, a 0-to-1 transition of the synchronised input sets a latch. The latch keeps pending_o[k] high after the input returns low.
- R7: In falling-edge mode, a 1-to-0 transition of the synchronised input sets a latch. The latch keeps pending_o[k] high after the input returns high.
- R8: Writing address 2 clears the edge latch of every line whose data bit is 1. Lines whose data bit is 0 keep their latch.
- R9: A write to address 2 has no effect on a line in a level mode.
- R10: When a new detected edge and a clear of the same line fall in the same cycle, the latch stays set.
- R11: Writing a different mode value into a line's field clears that line's edge latch.
- R12: Address 2 and the unused address 3 always read as 0. The enable register reads back in bits [5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 12 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| src_i | input | 6 | Raw asynchronous interrupt inputs |
| pending_o | output | 6 | Enabled interrupt requests |

## Verification
The bench builds the block with its default of six lines and a 32-bit read path. The sweep covers every combination of line index, trigger mode and enable state, so each mode-field position and each line's mask bit are exercised. In every combination it drives a low-high-low pulse and then clears, comparing against arithmetic predictions for all six outputs. Directed cases add the two-edge synchroniser latency, a clear landing in the same cycle as a detected edge, a mode switch while a latch is set, and a mask that hides a latch without losing it.

// File: rtl/irq_det_pkg.sv
package irq_det_pkg;
  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_mode_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_CLR  = 2'd2;
endpackage

// File: rtl/irq_det_sync.sv
module irq_det_sync #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/irq_det_regs.sv
module irq_det_regs
  import irq_det_pkg::*;
#(
  parameter int unsigned NSRC = 6,
  parameter int unsigned RD_W = 32,
  localparam int unsigned CFG_W = 2 * NSRC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [RD_W-1:0]  rdata_o,
  output logic [CFG_W-1:0] mode_o,
  output logic [NSRC-1:0]  en_o,
  output logic [NSRC-1:0]  clr_o,
  output logic [NSRC-1:0]  mode_chg_o
);
  logic [CFG_W-1:0] mode_q;
  logic [NSRC-1:0]  en_q;
  logic             wr_mode, wr_en, wr_clr;

  assign wr_mode = we_i && (addr_i == ADDR_MODE);
  assign wr_en   = we_i && (addr_i == ADDR_EN);
  assign wr_clr  = we_i && (addr_i == ADDR_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      en_q   <= '0;
    end else begin
      if (wr_mode) mode_q <= wdata_i;
      if (wr_en)   en_q   <= wdata_i[NSRC-1:0];
    end
  end

  // clear is a one-cycle strobe, never stored
  assign clr_o = wr_clr ? wdata_i[NSRC-1:0] : '0;

  for (genvar k = 0; k < NSRC; k++) begin : g_chg
    assign mode_chg_o[k] = wr_mode && (wdata_i[2*k +: 2] != mode_q[2*k +: 2]);
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_MODE: rdata_o[CFG_W-1:0] = mode_q;
      ADDR_EN:   rdata_o[NSRC-1:0]  = en_q;
      default:   rdata_o = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign en_o   = en_q;
endmodule

// File: rtl/irq_det_chan.sv
module irq_det_chan
  import irq_det_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic [1:0] mode_i,
  input  logic       clr_i,
  input  logic       mode_chg_i,
  output logic       req_o,
  output logic       lat_o
);
  trig_mode_e mode;
  logic       prev_q, lat_q, hit;

  assign mode = trig_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      TRIG_RISE: hit = lvl_i & ~prev_q;
      TRIG_FALL: hit = ~lvl_i & prev_q;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (mode_chg_i)  lat_q <= 1'b0;
      else if (hit)    lat_q <= 1'b1;  // new edge wins over a clear
      else if (clr_i)  lat_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (mode)
      TRIG_HIGH: req_o = lvl_i;
      TRIG_LOW:  req_o = ~lvl_i;
      default:   req_o = lat_q;
    endcase
  end

  assign lat_o = lat_q;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import irq_det_pkg::*;
#(
  parameter int unsigned NSRC = 6,
  parameter int unsigned RD_W = 32,
  localparam int unsigned CFG_W = 2 * NSRC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [CFG_W-1:0] reg_wdata_i,
  output logic [RD_W-1:0]  reg_rdata_o,
  input  logic [NSRC-1:0]  src_i,
  output logic [NSRC-1:0]  pending_o
);
  logic [CFG_W-1:0] mode_q;
  logic [NSRC-1:0]  en_q, clr_s, chg_s, lvl_s, req_s, edge_lat;

  irq_det_regs #(.NSRC(NSRC), .RD_W(RD_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .mode_o    (mode_q),
    .en_o      (en_q),
    .clr_o     (clr_s),
    .mode_chg_o(chg_s)
  );

  irq_det_sync #(.W(NSRC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (lvl_s)
  );

  for (genvar k = 0; k < NSRC; k++) begin : g_chan
    irq_det_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_i     (lvl_s[k]),
      .mode_i    (mode_q[2*k +: 2]),
      .clr_i     (clr_s[k]),
      .mode_chg_i(chg_s[k]),
      .req_o     (req_s[k]),
      .lat_o     (edge_lat[k])
    );
  end

  assign pending_o = req_s & en_q;
endmodule

// File: rtl/irq_det_chk.sv
module irq_det_chk
  import irq_det_pkg::*;
#(
  parameter int unsigned NSRC = 6,
  parameter int unsigned RD_W = 32,
  localparam int unsigned CFG_W = 2 * NSRC
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic [CFG_W-1:0] reg_wdata_i,
  input logic [RD_W-1:0]  reg_rdata_o,
  input logic [NSRC-1:0]  src_i,
  input logic [NSRC-1:0]  pending_o,
  input logic [CFG_W-1:0] mode_q,
  input logic [NSRC-1:0]  en_q,
  input logic [NSRC-1:0]  edge_lat
);
  logic [1:0] warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  p_clr_reads_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_CLR) |-> (reg_rdata_o == '0));

  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_MODE) |-> (reg_rdata_o[RD_W-1:CFG_W] == '0));

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    p_level_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q >= 2'd2 && mode_q[2*k +: 2] == TRIG_HIGH)
        |-> (pending_o[k] == (en_q[k] & $past(src_i[k], 2))));

    p_level_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q >= 2'd2 && mode_q[2*k +: 2] == TRIG_LOW)
        |-> (pending_o[k] == (en_q[k] & ~$past(src_i[k], 2))));

    p_edge_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q[2*k+1] && pending_o[k] && !reg_we_i) |=> pending_o[k]);

    p_mode_chg_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && reg_addr_i == ADDR_MODE && reg_wdata_i[2*k +: 2] != mode_q[2*k +: 2])
        |=> !edge_lat[k]);
  end
endmodule

bind ext_irq_detect irq_det_chk #(.NSRC(NSRC), .RD_W(RD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .src_i      (src_i),
  .pending_o  (pending_o),
  .mode_q     (mode_q),
  .en_q       (en_q),
  .edge_lat   (edge_lat)
);

// File: tb/ext_irq_detect_tb_top.sv
module ext_irq_detect_tb_top;
  localparam int NSRC = 6;
  localparam int CFG_W = 2 * NSRC;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             reg_we_i = 1'b0;
  logic [1:0]       reg_addr_i = '0;
  logic [CFG_W-1:0] reg_wdata_i = '0;
  logic [31:0]      reg_rdata_o;
  logic [NSRC-1:0]  src_i = '0;
  logic [NSRC-1:0]  pending_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  ext_irq_detect dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .src_i(src_i), .pending_o(pending_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CFG_W-1:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 v = reg_rdata_o;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [NSRC-1:0] bit_k, exp_p;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 pending", 32'(pending_o), 32'h0);
    rd(2'd0, v); check("R1 mode", v, 32'h0);
    rd(2'd1, v); check("R1 enable", v, 32'h0);
    rst_ni = 1'b1;
    settle(2);

    // R2 reserved bits, R12 readback
    wr(2'd0, 12'hFFF);
    rd(2'd0, v); check("R2 mode width", v, 32'h0000_0FFF);
    wr(2'd0, 12'h000);
    wr(2'd1, 6'h2A);
    rd(2'd1, v); check("R12 enable readback", v, 32'h2A);
    rd(2'd2, v); check("R12 clear reads 0", v, 32'h0);
    rd(2'd3, v); check("R12 addr3 reads 0", v, 32'h0);

    // R4 two-edge latency, line 0 high level
    wr(2'd1, 6'h01);
    @(negedge clk_i); src_i[0] = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    check("R4 not yet after one edge", 32'(pending_o), 32'h0);
    @(posedge clk_i); @(negedge clk_i);
    check("R4 visible after two edges", 32'(pending_o), 32'h1);
    src_i[0] = 1'b0;
    settle(3);

    // sweep line x mode x enable
    for (int k = 0; k < NSRC; k++) begin
      for (int m = 0; m < 4; m++) begin
        for (int e = 0; e < 2; e++) begin
          bit_k = NSRC'(1) << k;
          wr(2'd0, CFG_W'(m) << (2 * k));
          rd(2'd0, v); check("R2 field position", v, 32'(m) << (2 * k));
          wr(2'd1, e ? bit_k : '0);
          wr(2'd2, '1);
          settle(3);
          exp_p = (e == 1 && m == 1) ? bit_k : '0;
          check("R3/R5 idle low", 32'(pending_o), 32'(exp_p));
          src_i[k] = 1'b1;
          settle(4);
          exp_p = (e == 1 && (m == 0 || m == 2)) ? bit_k : '0;
          check("R3/R4/R6 input high", 32'(pending_o), 32'(exp_p));
          src_i[k] = 1'b0;
          settle(4);
          exp_p = (e == 1 && m != 0) ? bit_k : '0;
          check("R5/R6/R7 after pulse", 32'(pending_o), 32'(exp_p));
          wr(2'd2, ~bit_k);
          settle(1);
          check("R8 other bits keep latch", 32'(pending_o), 32'(exp_p));
          wr(2'd2, bit_k);
          settle(1);
          exp_p = (e == 1 && m == 1) ? bit_k : '0;
          check("R8/R9 clear own bit", 32'(pending_o), 32'(exp_p));
        end
      end
    end

    // R10 clear coincident with a detected edge, line 3 rising
    wr(2'd0, 12'(2'b10) << 6);
    wr(2'd1, 6'h08);
    wr(2'd2, 6'h3F);
    settle(2);
    @(negedge clk_i); src_i[3] = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    @(posedge clk_i);
    wr(2'd2, 6'h08);  // sampled on the edge where the rising edge is latched
    settle(1);
    check("R10 edge beats clear", 32'(pending_o), 32'h08);
    src_i[3] = 1'b0;
    settle(3);

    // R3 masking hides but keeps latch
    wr(2'd1, 6'h00);
    settle(1);
    check("R3 masked", 32'(pending_o), 32'h0);
    wr(2'd1, 6'h08);
    settle(1);
    check("R3 latch survives mask", 32'(pending_o), 32'h08);

    // R11 mode change clears latch (rising -> falling, input steady low)
    wr(2'd0, 12'(2'b11) << 6);
    settle(2);
    check("R11 mode change clears", 32'(pending_o), 32'h0);

    // R9 clear write with level-high line asserted
    wr(2'd0, 12'h000);
    wr(2'd1, 6'h3F);
    src_i = 6'h15;
    settle(4);
    wr(2'd2, 6'h3F);
    check("R9 level unaffected", 32'(pending_o), 32'h15);
    src_i = '0;
    settle(4);

    finish_run();
  end
endmodule